// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of a successive-approximation analog-to-digital converter. A conversion begins when the start input returns low after a high pulse. The block then raises a busy flag and builds its result one bit at a time, starting with the most significant bit. For each bit it places a trial word on the DAC bus and keeps or rejects the trial bit according to one comparator bit.

The block exports a gated conversion clock, which is low whenever the block is idle. Each bit period lasts two system clock cycles: one cycle with the conversion clock high, then one with it low. A full conversion produces one pulse more than the number of bits. The result is presented in complemented form, with a second copy whose sign bit is inverted for twos-complement use.

A resolution select can cut the cycle short at any width from 8 to 15 bits. Any other select value gives a full-width conversion. The select is captured when the conversion starts.

Top module: `sar_seq`

## Requirements
- R1: While reset is asserted and after it is released, `busy` and `conv_clk` are 0, `dac_word` is all zeros and `data_n` is all ones.
- R2: A conversion starts only on a high-to-low change of `conv_start` seen on two consecutive clock edges. On the edge that sees the low level, `busy` rises and `dac_word` is cleared. A held high level or a rising change starts nothing.
- R3: During a conversion of N bits, `conv_clk` gives exactly N+1 pulses, each one clock cycle high and one clock cycle low. The first pulse sets bit W-1 of `dac_word` as the trial bit, with all other bits 0.
- R4: Each later pulse settles the previous trial bit: it stays 1 if `cmp_above` was 1 at that edge and becomes 0 otherwise. The same pulse sets the next lower bit as the new trial bit. Bits are settled strictly from bit W-1 down to bit W-N, so the result for input value v is v with its lowest W-N bits cleared.
- R5: `busy` stays high for exactly 2N+2 clock cycles, then falls. `conv_clk` stays 0 from then until the next conversion.
- R6: The parallel outputs do not change in the cycle in which `busy` falls. Their last change comes one clock cycle earlier.
- R7: A `res_sel` value from 8 to 15, sampled on the start edge, sets N to that value. Any other value, 0 included, gives N = W = 16. Bits below bit W-N stay 0.
- R8: A high-to-low change of `conv_start` while `busy` is high is ignored. The running conversion, its length and its result are unaffected.
- R9: `data_n` is the bitwise inverse of `dac_word`. `data_ctc` equals `data_n` with bit W-1 inverted.
- R10: A change of `res_sel` during a conversion has no effect on that conversion's length or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | Convert command; the trailing edge starts a conversion |
| res_sel | input | 4 | Short-cycle resolution select |
| cmp_above | input | 1 | Comparator result: 1 means the input is at or above the DAC level |
| busy | output | 1 | High while a conversion runs |
| conv_clk | output | 1 | Gated conversion clock; low when idle |
| dac_word | output | 16 | Trial/result word in true form, drives the DAC |
| data_n | output | 16 | Complemented parallel result |
| data_ctc | output | 16 | Complemented result with the MSB inverted |

## Verification
The bench targets the following corner cases, each paired with the fault it would expose:
- Full-scale and zero inputs: a design that mishandles them would settle a wrong LSB or end with a stray trial bit left set.
- Every short-cycle width: a design that miscounts the stop point would make the `busy` window or the pulse count off by one, or would leave low-order bits set.
- Out-of-range and zero select values: a design that accepts them literally would stop far too early.
- A second start edge in mid-conversion, and a select change in mid-conversion: a design that reacts to either would restart the conversion or change its length.
- The cycle in which `busy` falls: a design whose data moves with the flag would fail a capture on that edge.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic {
    PH_RISE = 1'b0,
    PH_FALL = 1'b1
  } bit_phase_e;

  // Map a short-cycle select onto a bit count; anything unusable gives full width.
  function automatic int res_decode(int sel, int width, int lo);
    return (sel >= lo && sel < width) ? sel : width;
  endfunction

endpackage

// File: rtl/sar_start_det.sv
module sar_start_det (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic fall_o
);

  logic start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start_i;
  end

  assign fall_o = start_q & ~start_i;

endmodule

// File: rtl/sar_timer.sv
module sar_timer #(
  parameter int W       = 16,
  parameter int RSW     = 4,
  parameter int RES_MIN = 8,
  localparam int STEPW  = $clog2(W + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_i,
  input  logic [RSW-1:0]   res_sel_i,
  output logic             busy_o,
  output logic             cclk_o,
  output logic             init_o,
  output logic             edge_o,
  output logic [STEPW-1:0] step_o,
  output logic [STEPW-1:0] n_o
);
  import sar_pkg::*;

  logic             busy_q, busy_d;
  logic             cclk_q, cclk_d;
  bit_phase_e       ph_q, ph_d;
  logic [STEPW-1:0] step_q, step_d;
  logic [STEPW-1:0] n_q, n_d;
  logic             last_bit;

  assign init_o   = fall_i & ~busy_q;
  assign edge_o   = busy_q & (ph_q == PH_RISE);
  assign last_bit = (step_q == STEPW'(n_q + 1'b1));

  always_comb begin
    busy_d = busy_q;
    cclk_d = cclk_q;
    ph_d   = ph_q;
    step_d = step_q;
    n_d    = n_q;
    if (init_o) begin
      busy_d = 1'b1;
      cclk_d = 1'b0;
      ph_d   = PH_RISE;
      step_d = '0;
      n_d    = STEPW'(res_decode(int'(res_sel_i), W, RES_MIN));
    end else if (busy_q) begin
      if (ph_q == PH_RISE) begin
        cclk_d = 1'b1;
        ph_d   = PH_FALL;
        step_d = step_q + 1'b1;
      end else begin
        cclk_d = 1'b0;
        ph_d   = PH_RISE;
        if (last_bit) busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cclk_q <= 1'b0;
      ph_q   <= PH_RISE;
      step_q <= '0;
      n_q    <= STEPW'(W);
    end else begin
      busy_q <= busy_d;
      cclk_q <= cclk_d;
      ph_q   <= ph_d;
      step_q <= step_d;
      n_q    <= n_d;
    end
  end

  assign busy_o = busy_q;
  assign cclk_o = cclk_q;
  assign step_o = step_q;
  assign n_o    = n_q;

  // R5: the conversion clock is held low whenever no conversion runs
  a_r5_clk_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !cclk_q);

  // R3: a conversion clock pulse only ever starts inside a conversion
  a_r3_pulse_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cclk_q) |-> busy_q);

  // R8: a trailing start edge in mid-conversion does not rewind the step count
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && fall_i && step_q != '0) |=> (step_q != '0));

  // R7: the latched width is always a legal stop point
  a_r7_width_legal: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (n_q >= STEPW'(RES_MIN) && n_q <= STEPW'(W)));

endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int W      = 16,
  localparam int STEPW = $clog2(W + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_i,
  input  logic             edge_i,
  input  logic [STEPW-1:0] step_i,
  input  logic [STEPW-1:0] n_i,
  input  logic             cmp_i,
  output logic [W-1:0]     sar_o
);

  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] sar_q, sar_d;
  logic [W-1:0] cur_mask;
  logic         sar_en;

  // One-hot position of the bit decided at this edge (valid for step_i >= 1)
  assign cur_mask = (step_i == '0) ? '0 : (TOP_BIT >> (step_i - 1'b1));
  assign sar_en   = init_i | edge_i;

  always_comb begin
    sar_d = sar_q;
    if (init_i) begin
      sar_d = '0;
    end else if (edge_i) begin
      if (step_i == '0) begin
        sar_d = TOP_BIT;
      end else begin
        sar_d = sar_q & ~cur_mask;
        if (cmp_i)        sar_d = sar_d | cur_mask;
        if (step_i < n_i) sar_d = sar_d | (cur_mask >> 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sar_q <= '0;
    else if (sar_en) sar_q <= sar_d;
  end

  assign sar_o = sar_q;

  // R4: each decision edge touches at most the settled bit and the new trial bit
  a_r4_two_bits_move: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i && step_i != '0) |=> ($countones(sar_q ^ $past(sar_q)) <= 2));

  // R3: the first edge leaves exactly the top bit on trial
  a_r3_first_trial: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i && step_i == '0 && !init_i) |=> (sar_q == TOP_BIT));

endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int W       = 16,
  parameter int RSW     = 4,
  parameter int RES_MIN = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           conv_start,
  input  logic [RSW-1:0] res_sel,
  input  logic           cmp_above,
  output logic           busy,
  output logic           conv_clk,
  output logic [W-1:0]   dac_word,
  output logic [W-1:0]   data_n,
  output logic [W-1:0]   data_ctc
);

  localparam int STEPW = $clog2(W + 2);

  logic             start_fall;
  logic             init_w, edge_w;
  logic [STEPW-1:0] step_w, n_w;
  logic [W-1:0]     sar_w;

  sar_start_det u_det (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (conv_start),
    .fall_o  (start_fall)
  );

  sar_timer #(.W(W), .RSW(RSW), .RES_MIN(RES_MIN)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .fall_i    (start_fall),
    .res_sel_i (res_sel),
    .busy_o    (busy),
    .cclk_o    (conv_clk),
    .init_o    (init_w),
    .edge_o    (edge_w),
    .step_o    (step_w),
    .n_o       (n_w)
  );

  sar_approx #(.W(W)) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .init_i (init_w),
    .edge_i (edge_w),
    .step_i (step_w),
    .n_i    (n_w),
    .cmp_i  (cmp_above),
    .sar_o  (sar_w)
  );

  assign dac_word = sar_w;
  assign data_n   = ~sar_w;
  assign data_ctc = {sar_w[W-1], ~sar_w[W-2:0]};

  // R2: an accepted trailing edge starts a conversion from a cleared word
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (start_fall && !busy) |=> (busy && dac_word == '0));

  // R6: the result is already settled in the cycle the flag drops
  a_r6_data_before_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $stable(dac_word));

  // R7: bits below the stop point are still clear at the end
  a_r7_low_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ((dac_word & ({W{1'b1}} >> n_w)) == '0));

endmodule

// File: tb/sim_sar_seq.sv
`timescale 1ns/1ps
module sim_sar_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        conv_start;
  logic [3:0]  res_sel;
  logic        cmp_above;
  logic        busy, conv_clk;
  logic [15:0] dac_word, data_n, data_ctc;
  logic [15:0] vin;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  // Ideal comparator standing in for the analog front end
  assign cmp_above = (vin >= dac_word);

  sar_seq u0 (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .res_sel(res_sel),
    .cmp_above(cmp_above), .busy(busy), .conv_clk(conv_clk),
    .dac_word(dac_word), .data_n(data_n), .data_ctc(data_ctc)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: bit periods counted as integers
  bit          m_busy, m_clk, m_prev_start;
  logic [15:0] m_word;
  int          m_edge, m_half, m_bits;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_clk = 0; m_word = 0; m_edge = 0; m_half = 0;
      m_bits = 16; m_prev_start = 0;
    end else begin
      bit fell;
      fell = m_prev_start && !conv_start;
      m_prev_start = conv_start;
      if (!m_busy) begin
        if (fell) begin
          m_busy = 1; m_word = 0; m_edge = 0; m_half = 0;
          m_bits = (res_sel >= 8 && res_sel <= 15) ? int'(res_sel) : 16;
        end
      end else if (m_half == 0) begin
        m_clk = 1;
        if (m_edge == 0) m_word = 16'h8000;
        else begin
          int pos;
          pos = 16 - m_edge;
          m_word[pos] = (vin >= m_word);
          if (m_edge < m_bits) m_word[pos-1] = 1'b1;
        end
        m_edge++;
        m_half = 1;
      end else begin
        m_clk = 0;
        m_half = 0;
        if (m_edge == m_bits + 1) m_busy = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == m_busy, "R5 model busy", busy, m_busy);
      chk(conv_clk == m_clk, "R3 model conv_clk", conv_clk, m_clk);
      chk(dac_word == m_word, "R4 model dac_word", dac_word, m_word);
      chk(data_n == ~dac_word, "R9 data_n", data_n, ~dac_word);
    end
  end

  task automatic run(input logic [15:0] v, input logic [3:0] rs, input int n,
                     input bit poke, input bit chgres);
    logic [15:0] expw, prev_data;
    int blen, pulses, cyc;
    bit prev_clk;
    @(negedge clk); vin = v; res_sel = rs; conv_start = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R2 no start on high level", busy, 0);
    @(negedge clk); conv_start = 1'b0;
    chk(busy == 1'b0, "R2 no start on rising change", busy, 0);
    @(negedge clk);
    chk(busy == 1'b1, "R2 busy after trailing edge", busy, 1);
    chk(dac_word == 16'h0, "R2 word cleared", dac_word, 0);
    blen = 1; pulses = 0; cyc = 0; prev_clk = conv_clk; prev_data = data_n;
    while (busy) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 3) conv_start = 1'b1;
      if (poke && cyc == 5) conv_start = 1'b0;
      if (chgres && cyc == 4) res_sel = 4'd8;
      if (busy) blen++;
      if (conv_clk && !prev_clk) pulses++;
      if (!busy) chk(data_n == prev_data, "R6 data stable at flag fall", data_n, prev_data);
      prev_clk = conv_clk;
      prev_data = data_n;
    end
    expw = (v >> (16 - n)) << (16 - n);
    chk(blen == 2*n + 2, "R5 busy length", blen, 2*n + 2);
    chk(pulses == n + 1, "R3 pulse count", pulses, n + 1);
    chk(dac_word == expw, "R4 R7 result", dac_word, expw);
    chk(data_n == ~expw, "R9 complemented result", data_n, ~expw);
    chk(data_ctc == (~expw ^ 16'h8000), "R9 twos-complement form", data_ctc, ~expw ^ 16'h8000);
    repeat (3) begin
      @(negedge clk);
      chk(conv_clk == 1'b0 && busy == 1'b0, "R5 idle clock low", conv_clk, 0);
    end
  endtask

  initial begin
    rst_n = 1'b0; conv_start = 1'b0; res_sel = 4'd0; vin = 16'h0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && conv_clk == 0, "R1 reset flags", {busy, conv_clk}, 0);
    chk(dac_word == 0 && data_n == 16'hFFFF, "R1 reset data", data_n, 16'hFFFF);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && dac_word == 0, "R1 after release", dac_word, 0);

    run(16'h6A5C, 4'd0,  16, 0, 0);
    run(16'hFFFF, 4'd15, 15, 0, 0);
    run(16'hFFFF, 4'd0,  16, 0, 0);
    run(16'h0000, 4'd8,   8, 0, 0);
    run(16'h8000, 4'd12, 12, 0, 0);
    run(16'h1234, 4'd10, 10, 0, 0);
    run(16'h7FFF, 4'd9,   9, 0, 0);
    run(16'hBEEF, 4'd3,  16, 0, 0);   // R7 out-of-range select
    run(16'h2B71, 4'd13, 13, 0, 0);
    run(16'hC3A5, 4'd14, 14, 1, 0);   // R8 second trailing edge ignored
    run(16'h5A5A, 4'd0,  16, 0, 1);   // R10 select change ignored

    // R1: reset in mid-conversion returns everything to idle
    @(negedge clk); vin = 16'h4444; res_sel = 4'd0; conv_start = 1'b1;
    @(negedge clk); conv_start = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(busy == 0 && conv_clk == 0 && dac_word == 0, "R1 reset mid-conversion",
        dac_word, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule